// File: doc/BRIEF.md
# Significance-Tracking Single-Precision Multiplier

This block multiplies two 32-bit floating-point words that carry their own precision. In each normal operand the lowest set bit of the 23-bit fraction is a marker. The fraction bits above it are significant, and the marker and everything below it are noise. The block reads the marker to find each operand's precision and clears it to recover the value. It then multiplies the two values with truncation and writes the smaller of the two precisions back into the product as a new marker.

A normal operand whose fraction is all zero carries no significant fraction bits at all. Its value gives only the magnitude of the error. When such an operand takes part, the product is also an error-magnitude word, and a separate output flags it. Zeros, infinities and NaNs follow the ordinary rules and get no marker. Subnormal inputs are flushed to zero. The block is a two-stage pipeline with a fixed latency and accepts one operand pair per cycle.

Top module: `sigflt_mul`

## Requirements
- R1: `out_valid` is high exactly two cycles after a cycle with `in_valid` high and low otherwise. Results come out in input order, one per cycle.
- R2: For a normal operand (biased exponent 1 to 254), the lowest set bit of fraction bits [22:0] at position c is the marker. The operand precision is 22 − c, and the value used in the product is the fraction with that bit cleared.
- R3: A normal operand with an all-zero fraction has precision 0 and value 1.0 × 2^(e−127). Any product that involves it has an all-zero fraction.
- R4: The two 24-bit significands (hidden one included) are multiplied. The product is normalised by at most one position, incrementing the exponent when bit 47 is set, and the fraction is truncated.
- R5: For a normal result, p = min(pa, pb). If p ≥ 1, fraction bits above position 22 − p are kept, bit 22 − p is set and lower bits are cleared. If p = 0, the fraction is all zero.
- R6: The sign of every non-NaN result is the XOR of the operand signs.
- R7: An operand with exponent field 0 (zero or subnormal) times a finite operand gives a signed zero with an all-zero fraction.
- R8: Infinity times a normal or infinite operand gives signed infinity with a zero fraction. Infinity times zero, or any NaN operand, gives 0x7FC00000.
- R9: If the adjusted biased exponent reaches 255, the result is signed infinity. If it is 0 or below, the result is signed zero. Neither carries a marker.
- R10: While reset is held, `out_valid`, `out_res` and `out_errmag` are all zero.
- R11: `out_errmag` is high only with `out_valid`, and only for a normal result with precision 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First operand with precision marker |
| in_b | input | 32 | Second operand with precision marker |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Product with re-encoded precision marker |
| out_errmag | output | 1 | Result carries only an error magnitude |

## Verification
The assertions take the operands to be stable only in cycles where `in_valid` is high. They recompute the result precision from the operands two cycles back, so they rely on the inputs being sampled exactly once per accepted pair. The stimulus changes the inputs only at the falling clock edge. It holds `in_valid` low throughout reset, and it mixes idle gaps with back-to-back pairs so that the valid-to-result spacing is exercised. Random operands draw their exponent fields from bands that reach zero, the top value, and the overflow and underflow regions. They draw their marker positions across all 23 bits plus the all-zero fraction, so every operand class and precision is reached.

// File: rtl/sigflt_pkg.sv
// Package: shared operand classes and class-combining rule for the
// significance-tracking multiplier. Assumes binary32-like encoding.
package sigflt_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } sigflt_cls_e;

    // Combine operand classes into the class of their product.
    function automatic sigflt_cls_e merge_cls(input sigflt_cls_e x, input sigflt_cls_e y);
        if (x == CLS_NAN || y == CLS_NAN)
            return CLS_NAN;
        if ((x == CLS_INF && y == CLS_ZERO) || (x == CLS_ZERO && y == CLS_INF))
            return CLS_NAN;
        if (x == CLS_INF || y == CLS_INF)
            return CLS_INF;
        if (x == CLS_ZERO || y == CLS_ZERO)
            return CLS_ZERO;
        return CLS_NORM;
    endfunction

endpackage

// File: rtl/sigflt_unpack.sv
// Module: sigflt_unpack
// Splits one operand into sign, exponent, significand and class, finds the
// lowest set fraction bit (the precision marker), reports the precision and
// clears the marker from the significand. Purely combinational.
// Assumes: exponent field 0 means zero (subnormals are flushed).
module sigflt_unpack
    import sigflt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int PREC_W = $clog2(FRAC_W + 1)
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sign,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig,
    output logic [PREC_W-1:0]     prec,
    output sigflt_cls_e           cls
);
    localparam int POS_W = $clog2(FRAC_W);

    logic [FRAC_W-1:0] frac;
    logic [FRAC_W-1:0] stripped;
    logic [POS_W-1:0]  mark_pos;
    logic              mark_found;

    assign sign = op[EXP_W+FRAC_W];
    assign expo = op[FRAC_W +: EXP_W];
    assign frac = op[FRAC_W-1:0];

    // Locate the lowest set fraction bit.
    always_comb begin
        mark_pos   = '0;
        mark_found = 1'b0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (!mark_found && frac[i]) begin
                mark_pos   = POS_W'(i);
                mark_found = 1'b1;
            end
        end
    end

    // Clear the marker and derive the precision from its position.
    always_comb begin
        stripped = frac;
        if (mark_found)
            stripped[mark_pos] = 1'b0;
        prec = mark_found ? PREC_W'(FRAC_W - 1 - int'(mark_pos)) : '0;
        sig  = {1'b1, stripped};
    end

    // Classify the operand from its exponent field.
    always_comb begin
        if (expo == '0)
            cls = CLS_ZERO;
        else if (expo == '1)
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NORM;
    end

endmodule

// File: rtl/sigflt_stage1.sv
// Module: sigflt_stage1
// First pipeline stage: multiplies the two significands, adds the biased
// exponents, XORs the signs, takes the smaller precision and merges the
// classes, then registers all of it. Data registers load only on valid.
module sigflt_stage1
    import sigflt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int PREC_W = $clog2(FRAC_W + 1),
    parameter int SIG_W  = FRAC_W + 1,
    parameter int EW2    = EXP_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   a_sign,
    input  logic [EXP_W-1:0]       a_exp,
    input  logic [SIG_W-1:0]       a_sig,
    input  logic [PREC_W-1:0]      a_prec,
    input  sigflt_cls_e            a_cls,
    input  logic                   b_sign,
    input  logic [EXP_W-1:0]       b_exp,
    input  logic [SIG_W-1:0]       b_sig,
    input  logic [PREC_W-1:0]      b_prec,
    input  sigflt_cls_e            b_cls,
    output logic                   s1_valid,
    output logic                   s1_sign,
    output logic [2*SIG_W-1:0]     s1_prod,
    output logic signed [EW2-1:0]  s1_exp,
    output logic [PREC_W-1:0]      s1_prec,
    output sigflt_cls_e            s1_cls
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [2*SIG_W-1:0]    prod_c;
    logic signed [EW2-1:0] exp_c;
    logic [PREC_W-1:0]     prec_c;

    // Combinational product, exponent sum and precision minimum.
    always_comb begin
        prod_c = (2*SIG_W)'(a_sig) * (2*SIG_W)'(b_sig);
        exp_c  = EW2'(int'(a_exp) + int'(b_exp) - BIAS);
        prec_c = (a_prec < b_prec) ? a_prec : b_prec;
    end

    // Stage-1 valid register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_valid <= 1'b0;
        else
            s1_valid <= in_valid;
    end

    // Stage-1 data registers, loaded on accepted pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sign <= 1'b0;
            s1_prod <= '0;
            s1_exp  <= '0;
            s1_prec <= '0;
            s1_cls  <= CLS_ZERO;
        end else if (in_valid) begin
            s1_sign <= a_sign ^ b_sign;
            s1_prod <= prod_c;
            s1_exp  <= exp_c;
            s1_prec <= prec_c;
            s1_cls  <= merge_cls(a_cls, b_cls);
        end
    end

endmodule

// File: rtl/sigflt_pack.sv
// Module: sigflt_pack
// Second pipeline stage: normalises the product by at most one position,
// truncates the fraction, handles exponent overflow and underflow and the
// special classes, inserts the precision marker and registers the result.
// Assumes the product's top bit is bit 2*SIG_W-1 (both significands >= 1).
module sigflt_pack
    import sigflt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int PREC_W = $clog2(FRAC_W + 1),
    parameter int SIG_W  = FRAC_W + 1,
    parameter int EW2    = EXP_W + 2,
    parameter int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_valid,
    input  logic                   s1_sign,
    input  logic [2*SIG_W-1:0]     s1_prod,
    input  logic signed [EW2-1:0]  s1_exp,
    input  logic [PREC_W-1:0]      s1_prec,
    input  sigflt_cls_e            s1_cls,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_res,
    output logic                   out_errmag
);
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int PTOP    = 2 * SIG_W - 1;

    logic                  norm_up;
    logic [FRAC_W-1:0]     frac_t;
    logic signed [EW2-1:0] exp_adj;
    logic                  ovf;
    logic                  unf;
    logic [FRAC_W-1:0]     frac_m;
    logic [WORD_W-1:0]     res_c;
    logic                  errmag_c;

    // Normalise by one position and truncate the fraction.
    always_comb begin
        norm_up = s1_prod[PTOP];
        frac_t  = norm_up ? s1_prod[PTOP-1 -: FRAC_W] : s1_prod[PTOP-2 -: FRAC_W];
        exp_adj = s1_exp + EW2'(norm_up);
        ovf     = (exp_adj >= EW2'(EXP_MAX));
        unf     = exp_adj[EW2-1] || (exp_adj == '0);
    end

    // Insert the precision marker below the kept fraction bits.
    always_comb begin
        frac_m = '0;
        if (s1_prec != '0) begin
            for (int i = 0; i < FRAC_W; i++) begin
                if (i > FRAC_W - 1 - int'(s1_prec))
                    frac_m[i] = frac_t[i];
                else if (i == FRAC_W - 1 - int'(s1_prec))
                    frac_m[i] = 1'b1;
            end
        end
    end

    // Select the result word by class and exponent range.
    always_comb begin
        errmag_c = 1'b0;
        unique case (s1_cls)
            CLS_NAN:  res_c = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
            CLS_INF:  res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_ZERO: res_c = {s1_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
            default: begin
                if (ovf)
                    res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                else if (unf)
                    res_c = {s1_sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
                else begin
                    res_c    = {s1_sign, exp_adj[EXP_W-1:0], frac_m};
                    errmag_c = (s1_prec == '0);
                end
            end
        endcase
    end

    // Output registers: valid and error flag every cycle, word on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_errmag <= 1'b0;
            out_res    <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_errmag <= s1_valid && errmag_c;
            if (s1_valid)
                out_res <= res_c;
        end
    end

endmodule

// File: rtl/sigflt_mul.sv
// Module: sigflt_mul (top)
// Two-stage multiplier for binary32 words whose lowest set fraction bit marks
// their precision. Unpacks both operands, multiplies in stage 1, normalises
// and re-encodes with the smaller precision in stage 2. Latency two cycles.
// Assumes: inputs are sampled only when in_valid is high.
module sigflt_mul
    import sigflt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     in_a,
    input  logic [EXP_W+FRAC_W:0]     in_b,
    output logic                      out_valid,
    output logic [EXP_W+FRAC_W:0]     out_res,
    output logic                      out_errmag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PREC_W = $clog2(FRAC_W + 1);
    localparam int EW2    = EXP_W + 2;
    localparam int N_OPS  = 2;

    logic [N_OPS-1:0][WORD_W-1:0] ops;
    logic [N_OPS-1:0]             op_sign;
    logic [N_OPS-1:0][EXP_W-1:0]  op_exp;
    logic [N_OPS-1:0][SIG_W-1:0]  op_sig;
    logic [N_OPS-1:0][PREC_W-1:0] op_prec;
    sigflt_cls_e                  op_cls [N_OPS];

    logic                  s1_valid;
    logic                  s1_sign;
    logic [2*SIG_W-1:0]    s1_prod;
    logic signed [EW2-1:0] s1_exp;
    logic [PREC_W-1:0]     s1_prec;
    sigflt_cls_e           s1_cls;

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    // One unpacker per operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
        sigflt_unpack #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W),
            .PREC_W (PREC_W)
        ) u_unpack (
            .op   (ops[g]),
            .sign (op_sign[g]),
            .expo (op_exp[g]),
            .sig  (op_sig[g]),
            .prec (op_prec[g]),
            .cls  (op_cls[g])
        );
    end

    sigflt_stage1 #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .PREC_W (PREC_W),
        .SIG_W  (SIG_W),
        .EW2    (EW2)
    ) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .a_sign   (op_sign[0]),
        .a_exp    (op_exp[0]),
        .a_sig    (op_sig[0]),
        .a_prec   (op_prec[0]),
        .a_cls    (op_cls[0]),
        .b_sign   (op_sign[1]),
        .b_exp    (op_exp[1]),
        .b_sig    (op_sig[1]),
        .b_prec   (op_prec[1]),
        .b_cls    (op_cls[1]),
        .s1_valid (s1_valid),
        .s1_sign  (s1_sign),
        .s1_prod  (s1_prod),
        .s1_exp   (s1_exp),
        .s1_prec  (s1_prec),
        .s1_cls   (s1_cls)
    );

    sigflt_pack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .PREC_W (PREC_W),
        .SIG_W  (SIG_W),
        .EW2    (EW2),
        .WORD_W (WORD_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_sign    (s1_sign),
        .s1_prod    (s1_prod),
        .s1_exp     (s1_exp),
        .s1_prec    (s1_prec),
        .s1_cls     (s1_cls),
        .out_valid  (out_valid),
        .out_res    (out_res),
        .out_errmag (out_errmag)
    );

endmodule

// File: rtl/sigflt_mul_chk.sv
// Module: sigflt_mul_chk
// Property checker bound to sigflt_mul. Watches ports only and relates the
// outputs to the operands two cycles earlier.
module sigflt_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] in_a,
    input logic [EXP_W+FRAC_W:0] in_b,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_res,
    input logic                  out_errmag
);
    localparam int MSB = EXP_W + FRAC_W;

    // Precision carried by a word's marker (0 when the fraction is empty).
    function automatic int prec_of(input logic [EXP_W+FRAC_W:0] w);
        for (int i = 0; i < FRAC_W; i++)
            if (w[i])
                return FRAC_W - 1 - i;
        return 0;
    endfunction

    function automatic int min2(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    logic [EXP_W-1:0]  r_exp;
    logic [FRAC_W-1:0] r_frac;
    logic              r_normal;
    assign r_exp    = out_res[FRAC_W +: EXP_W];
    assign r_frac   = out_res[FRAC_W-1:0];
    assign r_normal = (r_exp != '0) && (r_exp != '1);

    AST_LATENCY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);  // R1
    AST_LATENCY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);  // R1
    AST_PREC_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_normal) |->
            prec_of(out_res) == min2(prec_of($past(in_a, 2)), prec_of($past(in_b, 2))));  // R5
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(r_exp == '1 && r_frac != '0)) |->
            out_res[MSB] == ($past(in_a[MSB], 2) ^ $past(in_b[MSB], 2)));  // R6
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_exp == '0) |-> r_frac == '0);  // R7
    AST_SPECIAL_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_exp == '1) |->
            (r_frac == '0 || r_frac == {1'b1, {(FRAC_W-1){1'b0}}}));  // R8
    AST_ERRMAG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_errmag |-> (out_valid && r_normal && r_frac == '0));  // R11

endmodule

bind sigflt_mul sigflt_mul_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_res    (out_res),
    .out_errmag (out_errmag)
);

// File: tb/sigflt_mul_bench.sv
`timescale 1ns/1ps
module sigflt_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_errmag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    bit          q_v[$];
    logic [32:0] q_r[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    sigflt_mul u_sigflt_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_res(out_res), .out_errmag(out_errmag)
    );

    // Behavioural reference: returns {errmag, result}.
    function automatic logic [32:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        int ea, eb, pa, pb, e, r, pos;
        longint fa, fb, m, frac;
        bit sgn, za, zb, ia, ib, na, nb;
        sgn = a[31] ^ b[31];
        ea = a[30:23]; eb = b[30:23];
        fa = a[22:0];  fb = b[22:0];
        za = (ea == 0); zb = (eb == 0);
        ia = (ea == 255) && (fa == 0); ib = (eb == 255) && (fb == 0);
        na = (ea == 255) && (fa != 0); nb = (eb == 255) && (fb != 0);
        if (na || nb || (ia && zb) || (ib && za)) return {1'b0, 32'h7FC0_0000};
        if (ia || ib) return {1'b0, sgn, 8'hFF, 23'd0};
        if (za || zb) return {1'b0, sgn, 31'd0};
        pa = 0; pb = 0;
        for (int c = 22; c >= 0; c--) if (fa[c]) pa = 22 - c;
        for (int c = 22; c >= 0; c--) if (fb[c]) pb = 22 - c;
        if (fa != 0) fa = fa - (longint'(1) << (22 - pa));
        if (fb != 0) fb = fb - (longint'(1) << (22 - pb));
        m = ((longint'(1) << 23) + fa) * ((longint'(1) << 23) + fb);
        e = ea + eb - 127;
        if (m >= (longint'(1) << 47)) begin
            frac = (m >> 24) % (longint'(1) << 23);
            e = e + 1;
        end else begin
            frac = (m >> 23) % (longint'(1) << 23);
        end
        if (e >= 255) return {1'b0, sgn, 8'hFF, 23'd0};
        if (e <= 0) return {1'b0, sgn, 31'd0};
        r = (pa < pb) ? pa : pb;
        if (r == 0) return {1'b1, sgn, 8'(e), 23'd0};
        pos = 22 - r;
        frac = ((frac >> (pos + 1)) << (pos + 1)) + (longint'(1) << pos);
        return {1'b0, sgn, 8'(e), 23'(frac)};
    endfunction

    // Compare outputs against the expectation queued two cycles earlier.
    task automatic check_head();
        bit          ev;
        logic [32:0] er;
        string       tg;
        ev = q_v.pop_front(); er = q_r.pop_front(); tg = q_tag.pop_front();
        n_checks++;
        if (ev) begin
            if (out_valid !== 1'b1 || out_res !== er[31:0] || out_errmag !== er[32]) begin
                n_fails++;
                $display("FAIL %s: valid %0b res %h errmag %0b, expected valid 1 res %h errmag %0b",
                         tg, out_valid, out_res, out_errmag, er[31:0], er[32]);
            end
        end else if (out_valid !== 1'b0 || out_errmag !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: valid %0b errmag %0b, expected valid 0 errmag 0",
                     out_valid, out_errmag);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        check_head();
        in_valid = v; in_a = a; in_b = b;
        q_v.push_back(v); q_r.push_back(ref_mul(a, b)); q_tag.push_back(tag);
    endtask

    function automatic logic [31:0] rand_op();
        int sel, ex, tz;
        logic [22:0] fr;
        sel = $urandom % 8;
        case (sel)
            0: ex = 0;
            1: ex = 255;
            2: ex = 200 + ($urandom % 55);
            3: ex = 1 + ($urandom % 20);
            default: ex = 100 + ($urandom % 55);
        endcase
        tz = $urandom % 24;
        fr = 23'($urandom);
        if (tz == 23) fr = '0;
        else fr = ((fr >> (tz + 1)) << (tz + 1)) | (23'd1 << tz);
        return {1'($urandom), 8'(ex), fr};
    endfunction

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R10: outputs held at zero during reset
        repeat (4) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_res !== 32'd0 || out_errmag !== 1'b0) begin
                n_fails++;
                $display("FAIL R10: valid %0b res %h errmag %0b, expected 0 0 0",
                         out_valid, out_res, out_errmag);
            end
        end
        rst_n = 1'b1;
        repeat (2) begin
            q_v.push_back(1'b0); q_r.push_back('0); q_tag.push_back("R1");
        end
        step(1, 32'h3F80_0001, 32'h3F80_0001, "R2");   // 1.0 at precision 22
        step(1, 32'h3F80_0400, 32'h3F80_0001, "R5");   // precision 12 wins
        step(1, 32'h3F80_0000, 32'h4000_0001, "R3");   // error-magnitude operand
        step(0, 32'h0, 32'h0, "R1");
        step(1, 32'h3FC0_0001, 32'h3FC0_0001, "R4");   // 1.5*1.5 normalises
        step(1, 32'h3FFF_FFFF, 32'h3FFF_FFFF, "R2");   // marker at bit 0 cleared
        step(1, 32'hBF80_0001, 32'h3F80_0001, "R6");
        step(1, 32'hBFC0_0100, 32'hC020_0001, "R6");
        step(1, 32'h0000_0000, 32'hBF80_0001, "R7");
        step(1, 32'h0000_0005, 32'h3F80_0001, "R7");   // subnormal flushed
        step(1, 32'h7F80_0000, 32'hBF80_0001, "R8");
        step(1, 32'h7F80_0000, 32'h0000_0000, "R8");
        step(1, 32'h7FC0_1234, 32'h3F80_0001, "R8");
        step(1, 32'h7F00_0001, 32'h7F00_0001, "R9");   // overflow
        step(1, 32'h0080_0001, 32'h0080_0001, "R9");   // underflow
        step(1, 32'h3F80_0000, 32'h3F80_0000, "R11");
        step(1, 32'h3FC0_0000, 32'h4040_0000, "R3");
        for (int k = 0; k < 3000; k++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, rand_op(), rand_op(), "R4");
        end
        step(0, 32'h0, 32'h0, "R1");
        step(0, 32'h0, 32'h0, "R1");
        step(0, 32'h0, 32'h0, "R1");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule